// File: doc/BRIEF.md
# Local Bus Address Decoder with Boot Overlay

This block sits between the processor of a 16-bit card and its local resources. It takes the word address of each bus cycle (address bits 23 down to 1) and raises one of seven select lines: boot ROM, the peripheral controller, the board control register, the cache-clear strobe region, local RAM, the 24-bit off-board window and the 16-bit off-board window. It also steers read data from the selected source back onto one 16-bit return bus. Regions that are mirrored are decoded from the high address bits only. The local RAM size is set by a parameter, either 128 KB or 512 KB. Whatever lies between the end of RAM and the I/O page goes to the 24-bit off-board window.

Straight after reset, reads of the eight-byte reset vector area are served from boot ROM so that the processor can fetch its initial stack pointer and program counter. Once a set number of such reads has completed, the overlay ends and RAM shows through at those addresses. The backplane itself is not modelled. Every off-board access ends at once in a timeout: the read returns zero, and on the following cycle the block gives a one-cycle bus-error pulse to the processor and a one-cycle pulse on an interrupt input of the peripheral controller.

Top module: `lbus_decode`

## Requirements
- R1: Byte addresses 0xF00000–0xF1FFFF assert select bit 0 (ROM). rom_word_o equals address bits 16:1, and a read returns rom_rdata_i.
- R2: Byte addresses 0xF20000–0xF3FFFF assert select bit 1 (peripheral). per_idx_o equals address bits 5:1, and a read returns 0xFF in the upper byte with per_rdata_i in the lower byte.
- R3: Byte addresses 0xF40000–0xF5FFFF assert select bit 2 (control register). A read returns 0xFF in the upper byte with ctl_rdata_i in the lower byte.
- R4: Byte addresses 0xF80000–0xF9FFFF assert select bit 3 (cache clear) when HAS_CACHE is 1. A write there drives cache_clr_o[0] (bank 1) from address bit 2 and cache_clr_o[1] (bank 2) from address bit 1, so offset 2 clears bank 2, offset 4 clears bank 1 and offset 6 clears both. Reads, and accesses to any other region, leave cache_clr_o at 0. A read of this region returns 0xFFFF.
- R5: Byte addresses from 0 up to RAM_KB*1024−1 assert select bit 4 (RAM), and a read returns ram_rdata_i. The boot overlay of R9 takes precedence.
- R6: Select bit 5 (24-bit window) covers the range from RAM_KB*1024 to 0xEFFFFF and the range 0xFA0000–0xFEFFFF. Select bit 6 (16-bit window) covers 0xFF0000–0xFFFFFF. A read of either window returns 0.
- R7: An access (req_i high) that selects either off-board window makes berr_o and tmo_irq_o high during the next cycle only. In every other case both are low.
- R8: Byte addresses 0xF60000–0xF7FFFF select nothing and a read there returns 0xFFFF.
- R9: After reset, the first BOOT_READS (default 4) completed reads of byte addresses 0x000000–0x000007 assert the ROM select and return rom_rdata_i. Later reads of those addresses select RAM.
- R10: A write to 0x000000–0x000007 selects RAM even while the overlay is active. Neither writes nor reads of any other address advance the overlay count.
- R11: At most one select bit is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Bus cycle completes this clock |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 23 | Word address, byte address bits 23:1 |
| rom_rdata_i | input | 16 | Boot ROM read data |
| ram_rdata_i | input | 16 | Local RAM read data |
| per_rdata_i | input | 8 | Peripheral controller read byte |
| ctl_rdata_i | input | 8 | Control register read byte |
| sel_o | output | 7 | One-hot region select: bit 0 ROM, 1 peripheral, 2 control, 3 cache clear, 4 RAM, 5 24-bit window, 6 16-bit window |
| rom_word_o | output | 16 | ROM word index |
| per_idx_o | output | 5 | Peripheral register index |
| cache_clr_o | output | 2 | Cache-clear strobes: bit 0 bank 1, bit 1 bank 2 |
| rdata_o | output | 16 | Read data to the processor |
| berr_o | output | 1 | Bus-error pulse |
| tmo_irq_o | output | 1 | Timeout pulse to the peripheral interrupt input |

## Verification
The select lines, the indices, the cache-clear strobes and the read data are combinational and due in the same cycle as the address. The bench therefore drives each access just after a falling edge and checks these outputs 1 ns later, before the next rising edge. The bus-error and timeout pulses come out of a register. Each access therefore compares them against what the access in the previous cycle should have produced, and idle cycles check that the pulses do not last longer. The overlay count changes at the rising edge that ends each vector read, so the expected count in the bench advances only once the checks of that read are done.

// File: rtl/lbus_pkg.sv
package lbus_pkg;
   localparam int DATA_W   = 16;
   localparam int LANE_W   = DATA_W / 2;
   localparam int SEL_W    = 7;
   localparam int SEL_ROM  = 0;
   localparam int SEL_PER  = 1;
   localparam int SEL_CTL  = 2;
   localparam int SEL_CCLR = 3;
   localparam int SEL_RAM  = 4;
   localparam int SEL_A24  = 5;
   localparam int SEL_A16  = 6;
endpackage

// File: rtl/lbus_region_dec.sv
module lbus_region_dec
   import lbus_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int RAM_KB    = 128,
   parameter bit HAS_CACHE = 1'b1
) (
   input  logic [ADDR_W-1:3] addr_i,
   input  logic              wr_i,
   input  logic              vec_i,
   input  logic              ovl_i,
   output logic [SEL_W-1:0]  sel_o
);
   localparam int RAM_AW = $clog2(RAM_KB * 1024);

   logic             io_page;
   logic             ram_hit;
   logic             cache_ok;
   logic [SEL_W-1:0] io_sel;

   assign io_page = &addr_i[ADDR_W-1:ADDR_W-4];
   assign ram_hit = ~|addr_i[ADDR_W-1:RAM_AW];

   generate
      if (HAS_CACHE) begin : g_cache
         assign cache_ok = 1'b1;
      end else begin : g_nocache
         assign cache_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      io_sel = '0;
      case (addr_i[ADDR_W-5:ADDR_W-7])
         3'd0:    io_sel[SEL_ROM]  = 1'b1;
         3'd1:    io_sel[SEL_PER]  = 1'b1;
         3'd2:    io_sel[SEL_CTL]  = 1'b1;
         3'd3:    io_sel           = '0;
         3'd4:    io_sel[SEL_CCLR] = cache_ok;
         3'd5,
         3'd6:    io_sel[SEL_A24]  = 1'b1;
         default: begin
            if (addr_i[ADDR_W-8]) io_sel[SEL_A16] = 1'b1;
            else                  io_sel[SEL_A24] = 1'b1;
         end
      endcase

      sel_o = '0;
      if (io_page)                     sel_o = io_sel;
      else if (vec_i && ovl_i && !wr_i) sel_o[SEL_ROM] = 1'b1;
      else if (ram_hit)                sel_o[SEL_RAM] = 1'b1;
      else                             sel_o[SEL_A24] = 1'b1;
   end
endmodule

// File: rtl/lbus_boot_ovl.sv
module lbus_boot_ovl #(
   parameter int BOOT_READS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vec_rd_i,
   output logic ovl_o
);
   localparam int CNT_W = $clog2(BOOT_READS + 1);

   logic [CNT_W-1:0] rd_cnt;

   assign ovl_o = (rd_cnt < CNT_W'(BOOT_READS));

   always_ff @(posedge clk) begin
      if (!rst_n)                rd_cnt <= '0;
      else if (vec_rd_i && ovl_o) rd_cnt <= rd_cnt + 1'b1;
   end
endmodule

// File: rtl/lbus_offboard_tmo.sv
module lbus_offboard_tmo (
   input  logic clk,
   input  logic rst_n,
   input  logic hit_i,
   output logic berr_o,
   output logic irq_o
);
   logic pulse_q;

   always_ff @(posedge clk) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= hit_i;
   end

   assign berr_o = pulse_q;
   assign irq_o  = pulse_q;
endmodule

// File: rtl/lbus_decode.sv
module lbus_decode
   import lbus_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int RAM_KB     = 128,
   parameter bit HAS_CACHE  = 1'b1,
   parameter int BOOT_READS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:1] addr_i,
   input  logic [DATA_W-1:0] rom_rdata_i,
   input  logic [DATA_W-1:0] ram_rdata_i,
   input  logic [LANE_W-1:0] per_rdata_i,
   input  logic [LANE_W-1:0] ctl_rdata_i,
   output logic [SEL_W-1:0]  sel_o,
   output logic [15:0]       rom_word_o,
   output logic [4:0]        per_idx_o,
   output logic [1:0]        cache_clr_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              berr_o,
   output logic              tmo_irq_o
);
   generate
      if (ADDR_W != 24) begin : g_bad_aw
         $error("lbus_decode: map is laid out for a 24-bit address");
      end
      if (RAM_KB != 128 && RAM_KB != 512) begin : g_bad_ram
         $error("lbus_decode: RAM_KB must be 128 or 512");
      end
      if (BOOT_READS < 1) begin : g_bad_boot
         $error("lbus_decode: BOOT_READS must be at least 1");
      end
   endgenerate

   logic vec_hit;
   logic ovl;
   logic off_hit;

   assign vec_hit = ~|addr_i[ADDR_W-1:3];

   lbus_boot_ovl #(.BOOT_READS(BOOT_READS)) u_ovl (
      .clk      (clk),
      .rst_n    (rst_n),
      .vec_rd_i (req_i & ~we_i & vec_hit),
      .ovl_o    (ovl)
   );

   lbus_region_dec #(
      .ADDR_W    (ADDR_W),
      .RAM_KB    (RAM_KB),
      .HAS_CACHE (HAS_CACHE)
   ) u_dec (
      .addr_i (addr_i[ADDR_W-1:3]),
      .wr_i   (we_i),
      .vec_i  (vec_hit),
      .ovl_i  (ovl),
      .sel_o  (sel_o)
   );

   assign off_hit = req_i & (sel_o[SEL_A24] | sel_o[SEL_A16]);

   lbus_offboard_tmo u_tmo (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit_i  (off_hit),
      .berr_o (berr_o),
      .irq_o  (tmo_irq_o)
   );

   assign rom_word_o  = addr_i[16:1];
   assign per_idx_o   = addr_i[5:1];
   assign cache_clr_o = (req_i && we_i && sel_o[SEL_CCLR]) ? {addr_i[1], addr_i[2]} : 2'b00;

   always_comb begin
      rdata_o = '1;
      case (1'b1)
         sel_o[SEL_ROM]: rdata_o = rom_rdata_i;
         sel_o[SEL_RAM]: rdata_o = ram_rdata_i;
         sel_o[SEL_PER]: rdata_o = {{LANE_W{1'b1}}, per_rdata_i};
         sel_o[SEL_CTL]: rdata_o = {{LANE_W{1'b1}}, ctl_rdata_i};
         sel_o[SEL_A24],
         sel_o[SEL_A16]: rdata_o = '0;
         default:        rdata_o = '1;
      endcase
   end
endmodule

// File: rtl/lbus_decode_chk.sv
module lbus_decode_chk
   import lbus_pkg::*;
#(
   parameter int ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_i,
   input logic              we_i,
   input logic [ADDR_W-1:1] addr_i,
   input logic [SEL_W-1:0]  sel_o,
   input logic [1:0]        cache_clr_o,
   input logic [DATA_W-1:0] rdata_o,
   input logic              berr_o,
   input logic              tmo_irq_o
);
   // R11
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_o));

   // R7
   berr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && (sel_o[SEL_A24] || sel_o[SEL_A16])) |=> (berr_o && tmo_irq_o));

   // R7
   berr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_i && (sel_o[SEL_A24] || sel_o[SEL_A16])) |=> (!berr_o && !tmo_irq_o));

   // R6
   offboard_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_o[SEL_A24] || sel_o[SEL_A16]) |-> (rdata_o == '0));

   // R8
   hole_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_o == '0) |-> (rdata_o == '1));

   // R4
   clr_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cache_clr_o != 2'b00) |-> (req_i && we_i && sel_o[SEL_CCLR]));

   // R10
   vec_write_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && addr_i[ADDR_W-1:3] == '0) |-> sel_o[SEL_RAM]);
endmodule

bind lbus_decode lbus_decode_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_i       (req_i),
   .we_i        (we_i),
   .addr_i      (addr_i),
   .sel_o       (sel_o),
   .cache_clr_o (cache_clr_o),
   .rdata_o     (rdata_o),
   .berr_o      (berr_o),
   .tmo_irq_o   (tmo_irq_o)
);

// File: tb/lbus_decode_test.sv
`timescale 1ns/1ps
module lbus_decode_test;
   localparam int RAM_TOP = 128 * 1024;
   localparam logic [15:0] ROM_D = 16'hB00F;
   localparam logic [15:0] RAM_D = 16'h5A5A;
   localparam logic [7:0]  PER_D = 8'h3C;
   localparam logic [7:0]  CTL_D = 8'hC7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        we = 1'b0;
   logic [23:1] addr = '0;
   logic [6:0]  sel;
   logic [15:0] rom_word;
   logic [4:0]  per_idx;
   logic [1:0]  clr;
   logic [15:0] rdata;
   logic        berr, tirq;

   int tests = 0;
   int fails = 0;
   int vec_reads = 0;
   bit prev_off = 1'b0;

   always #2 clk = ~clk;

   lbus_decode uut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
      .rom_rdata_i(ROM_D), .ram_rdata_i(RAM_D), .per_rdata_i(PER_D), .ctl_rdata_i(CTL_D),
      .sel_o(sel), .rom_word_o(rom_word), .per_idx_o(per_idx), .cache_clr_o(clr),
      .rdata_o(rdata), .berr_o(berr), .tmo_irq_o(tirq)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [6:0] exp_sel(input logic [23:0] a, input bit w, input bit ovl);
      if (a <= 24'h7 && !w && ovl) return 7'b0000001;
      if (a < RAM_TOP)             return 7'b0010000;
      if (a < 24'hF00000)          return 7'b0100000;
      if (a < 24'hF20000)          return 7'b0000001;
      if (a < 24'hF40000)          return 7'b0000010;
      if (a < 24'hF60000)          return 7'b0000100;
      if (a < 24'hF80000)          return 7'b0000000;
      if (a < 24'hFA0000)          return 7'b0001000;
      if (a < 24'hFF0000)          return 7'b0100000;
      return 7'b1000000;
   endfunction

   function automatic logic [15:0] exp_data(input logic [6:0] s);
      case (s)
         7'b0000001: return ROM_D;
         7'b0010000: return RAM_D;
         7'b0000010: return {8'hFF, PER_D};
         7'b0000100: return {8'hFF, CTL_D};
         7'b0100000, 7'b1000000: return 16'h0000;
         default: return 16'hFFFF;
      endcase
   endfunction

   task automatic access(input logic [23:0] a, input bit w);
      logic [6:0] es;
      logic [1:0] ec;
      @(negedge clk);
      req = 1'b1; we = w; addr = a[23:1];
      #1;
      es = exp_sel(a, w, vec_reads < 4);
      ec = 2'b00;
      if (w && es[3]) ec = {a[1], a[2]};
      check(sel == es, "R1/R2/R3/R5/R6/R8/R9 select", {25'd0, sel}, {25'd0, es});
      if (!w) check(rdata == exp_data(es), "R1/R2/R3/R5/R6/R8 read data", {16'd0, rdata}, {16'd0, exp_data(es)});
      check(clr == ec, "R4 cache clear", {30'd0, clr}, {30'd0, ec});
      check(berr == prev_off && tirq == prev_off, "R7 pulse", {30'd0, berr, tirq}, {30'd0, prev_off, prev_off});
      if (es[0]) check(rom_word == a[16:1], "R1 rom word", {16'd0, rom_word}, {16'd0, a[16:1]});
      if (es[1]) check(per_idx == a[5:1], "R2 periph index", {27'd0, per_idx}, {27'd0, a[5:1]});
      check($countones(sel) <= 1, "R11 one-hot", {25'd0, sel}, 32'd0);
      prev_off = es[5] | es[6];
      if (!w && a <= 24'h7 && vec_reads < 4) vec_reads++;
   endtask

   task automatic idle();
      @(negedge clk);
      req = 1'b0; we = 1'b0;
      #1;
      check(berr == prev_off && tirq == prev_off, "R7 pulse end", {30'd0, berr, tirq}, {30'd0, prev_off, prev_off});
      prev_off = 1'b0;
   endtask

   initial begin
      #600000;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [23:0] bounds [18];
      repeat (3) @(negedge clk);
      #1;
      check(berr == 1'b0 && tirq == 1'b0, "R7 reset pulses low", {30'd0, berr, tirq}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(sel == 7'b0000001, "R9 vector reads ROM after reset", {25'd0, sel}, 32'd1);

      // R9 R10: overlay with interleaved writes and non-vector reads
      access(24'h000000, 1'b0);
      access(24'h000000, 1'b1);   // R10 write goes to RAM
      access(24'h000100, 1'b0);   // R10 not counted
      access(24'h000002, 1'b0);
      access(24'h000004, 1'b1);
      access(24'h000004, 1'b0);
      idle();
      access(24'h000006, 1'b0);   // fourth read
      access(24'h000000, 1'b0);   // R9 now RAM
      access(24'h000006, 1'b0);
      check(vec_reads == 4, "R9 overlay count", vec_reads, 4);

      // region edges
      bounds = '{24'h01FFFE, 24'h020000, 24'hEFFFFE, 24'hF00000, 24'hF1FFFE,
                 24'hF20000, 24'hF3FFFE, 24'hF40000, 24'hF5FFFE, 24'hF60000,
                 24'hF7FFFE, 24'hF80000, 24'hF9FFFE, 24'hFA0000, 24'hFEFFFE,
                 24'hFF0000, 24'hFFFFFE, 24'h000008};
      foreach (bounds[i]) begin
         access(bounds[i], 1'b0);
         if (i % 3 == 0) idle();
      end

      // R4 cache-clear strobes and mirrors
      for (int k = 0; k < 8; k++) begin
         access(24'hF80000 + 24'(2 * k), 1'b1);
         access(24'hF9FFF0 + 24'(2 * k), 1'b1);
         access(24'hF80000 + 24'(2 * k), 1'b0);
      end
      access(24'h000010, 1'b1);
      access(24'hF20006, 1'b1);

      // sweep across the whole map
      for (int i = 0; i < 4096; i++) begin
         access({i[11:0], 12'((i * 37) & 12'hFFE)}, 1'b0);
         if (i % 5 == 0) idle();
      end
      for (int i = 0; i < 512; i++) begin
         access({i[8:0], 3'd0, 12'((i * 91) & 12'hFFE)}, 1'b1);
      end
      idle();
      idle();

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule